// File: doc/BRIEF.md
# Memory Window Address Decoder

This block sits between a parallel system bus and a two-bank DRAM array. When the bus address strobe rises, it decides whether the byte address on the bus falls inside a memory window, and it produces the word address to send to the array and the bank to enable. The window is set by a start setting in 8 KB steps and a size setting in 16 KB and 256 KB steps. An address-width mode sets how many bus address bits are significant. A reserved I/O page at the top of the addressed space never decodes as memory.

The array address is not the offset from the window start. It is the bus address taken modulo the physical capacity. If the start is not a multiple of the capacity, the window therefore wraps inside the array. A strap input chooses between two array builds. In the small build, each bank holds 64K words and the bank bit is bus address bit 17. In the large build, each bank holds 256K words and the bank bit is bus address bit 19.

Top module: `memwin_decode`

## Requirements
- R1: `hit_o` is 1 only when base <= A < base + size and A is not in the I/O page, where A is the masked address. The base is `base_hi`*256 KB + `base_lo`*8 KB. Both window boundaries are compared at 8 KB granularity.
- R2: The window size is `size_hi`*256 KB + (`size_lo`+1)*16 KB. This gives 16 KB to 1024 KB.
- R3: `local_o` is the masked byte address with bit 0 dropped. Bits 15:0 of `local_o` are bus bits 16:1. No base is subtracted.
- R4: When `dev_large`=0, `bank_o` is masked bit 17 and `local_o[17:16]` is 0. When `dev_large`=1, `local_o[17:16]` is masked bits 18:17 and `bank_o` is masked bit 19.
- R5: `width_mode` values 0, 1, 2, 3 and 4 select 18, 19, 20, 21 and 22 significant address bits. Address bits at or above the selected width are treated as 0.
- R6: The I/O page is the top 2 KB, 4 KB or 8 KB of the selected address space, for `iopage_sel` = 0, 1 and 2-or-3. An address inside it never gives `hit_o`=1.
- R7: The inputs are sampled only on a clock edge where `addr_strobe` is 1 and was 0 at the previous edge. The outputs change after that edge and hold otherwise, including while the strobe stays high.
- R8: While `rst_n` is 0, `hit_o`, `local_o` and `bank_o` are 0.
- R9: `width_mode` values 5 to 7 behave as the 22-bit setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Bus address strobe; its rising edge samples the inputs |
| bus_addr | input | 22 | Bus byte address |
| base_lo | input | 5 | Start address, 8 KB steps |
| base_hi | input | 4 | Start address, 256 KB steps |
| size_lo | input | 4 | Size minus 16 KB, in 16 KB steps |
| size_hi | input | 2 | Additional size, 256 KB steps |
| width_mode | input | 3 | Significant bus address width code |
| iopage_sel | input | 2 | I/O page size code |
| dev_large | input | 1 | Strap: 1 selects the 256K-word-per-bank array |
| hit_o | output | 1 | Address decodes to this memory |
| local_o | output | 18 | Array word address |
| bank_o | output | 1 | Bank select |

## Verification
The bench uses the default build: a 22-bit bus, an 18-bit minimum width and an 18-bit local address. With these settings every width code is reachable, including the codes above 4, and both strap builds can be driven at run time. Because the space is 22 bits wide, the largest start setting (4088 KB) is reachable. A window that starts there runs past the top of the space and overlaps the I/O page, so the I/O exclusion can be tested inside a live window for all three page sizes.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
   // number of width codes above the minimum width
   localparam int WIDTH_STEPS = 4;
   // I/O page size codes above the smallest page
   localparam int IO_STEPS = 2;

   function automatic int unsigned clamp_code(input int unsigned code, input int unsigned top);
      return (code > top) ? top : code;
   endfunction
endpackage

// File: rtl/memwin_addr_mask.sv
module memwin_addr_mask #(
   parameter int ADDR_W = 22,
   parameter int MIN_AW = 18,
   localparam int WID_W = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [2:0]        mode_i,
   output logic [ADDR_W-1:0] masked_o,
   output logic [WID_W-1:0]  width_o
);
   import memwin_pkg::*;

   logic [2:0] code_eff;

   always_comb begin
      code_eff = (mode_i > 3'(WIDTH_STEPS)) ? 3'(WIDTH_STEPS) : mode_i;
      width_o  = WID_W'(MIN_AW) + WID_W'(code_eff);
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < MIN_AW) begin : g_keep
         assign masked_o[i] = addr_i[i];
      end else begin : g_gate
         assign masked_o[i] = addr_i[i] & (width_o > WID_W'(i));
      end
   end
endmodule

// File: rtl/memwin_io_guard.sv
module memwin_io_guard #(
   parameter int ADDR_W  = 22,
   parameter int IO_LSB0 = 11,
   localparam int WID_W  = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] masked_i,
   input  logic [WID_W-1:0]  width_i,
   input  logic [1:0]        sel_i,
   output logic              in_io_o
);
   import memwin_pkg::*;

   logic [WID_W-1:0]  io_lsb;
   logic [ADDR_W-1:0] need_one;

   always_comb begin
      io_lsb = WID_W'(IO_LSB0) + ((sel_i > 2'(IO_STEPS)) ? WID_W'(IO_STEPS) : WID_W'(sel_i));
   end

   // a bit must be set when it lies between the page floor and the width top
   for (genvar i = 0; i < ADDR_W; i++) begin : g_need
      assign need_one[i] = (width_i > WID_W'(i)) && (io_lsb <= WID_W'(i));
   end

   assign in_io_o = &(masked_i | ~need_one);
endmodule

// File: rtl/memwin_range_cmp.sv
module memwin_range_cmp #(
   parameter int BLK_W     = 9,
   parameter int BASE_LO_W = 5,
   parameter int SIZE_LO_W = 4,
   parameter int SIZE_HI_W = 2,
   localparam int END_W    = BLK_W + 1,
   localparam int BASE_HI_W = BLK_W - BASE_LO_W
) (
   input  logic [BLK_W-1:0]     blk_i,
   input  logic [BASE_LO_W-1:0] base_lo_i,
   input  logic [BASE_HI_W-1:0] base_hi_i,
   input  logic [SIZE_LO_W-1:0] size_lo_i,
   input  logic [SIZE_HI_W-1:0] size_hi_i,
   output logic                 in_win_o
);
   logic [BLK_W-1:0] base_u;
   logic [END_W-1:0] size_u;
   logic [END_W-1:0] end_u;

   always_comb begin
      base_u   = {base_hi_i, base_lo_i};
      size_u   = (END_W'(size_hi_i) << BASE_LO_W) + ((END_W'(size_lo_i) + END_W'(1)) << 1);
      end_u    = END_W'(base_u) + size_u;
      in_win_o = (blk_i >= base_u) && (END_W'(blk_i) < end_u);
   end
endmodule

// File: rtl/memwin_local_map.sv
module memwin_local_map #(
   parameter int ADDR_W       = 22,
   parameter int SMALL_DEV_AW = 16,
   parameter int LOC_W        = 18
) (
   input  logic [ADDR_W-1:0] masked_i,
   input  logic              large_i,
   output logic [LOC_W-1:0]  local_o,
   output logic              bank_o
);
   for (genvar i = 0; i < LOC_W; i++) begin : g_loc
      if (i < SMALL_DEV_AW) begin : g_common
         assign local_o[i] = masked_i[i+1];
      end else begin : g_large_only
         assign local_o[i] = large_i & masked_i[i+1];
      end
   end

   assign bank_o = large_i ? masked_i[LOC_W+1] : masked_i[SMALL_DEV_AW+1];
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode #(
   parameter int ADDR_W       = 22,
   parameter int MIN_AW       = 18,
   parameter int BLK_LSB      = 13,
   parameter int BASE_LO_W    = 5,
   parameter int SIZE_LO_W    = 4,
   parameter int SIZE_HI_W    = 2,
   parameter int IO_LSB0      = 11,
   parameter int SMALL_DEV_AW = 16,
   parameter int LOC_W        = 18,
   localparam int BLK_W       = ADDR_W - BLK_LSB,
   localparam int BASE_HI_W   = BLK_W - BASE_LO_W,
   localparam int WID_W       = $clog2(ADDR_W + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_strobe,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BASE_LO_W-1:0] base_lo,
   input  logic [BASE_HI_W-1:0] base_hi,
   input  logic [SIZE_LO_W-1:0] size_lo,
   input  logic [SIZE_HI_W-1:0] size_hi,
   input  logic [2:0]           width_mode,
   input  logic [1:0]           iopage_sel,
   input  logic                 dev_large,
   output logic                 hit_o,
   output logic [LOC_W-1:0]     local_o,
   output logic                 bank_o
);
   if (MIN_AW + memwin_pkg::WIDTH_STEPS != ADDR_W) begin : g_bad_width
      $error("memwin_decode: ADDR_W must equal MIN_AW plus the width steps");
   end
   if (LOC_W + 2 > MIN_AW + 2 || SMALL_DEV_AW >= LOC_W) begin : g_bad_loc
      $error("memwin_decode: local width inconsistent with minimum address width");
   end
   if (BLK_LSB <= IO_LSB0 - 1 || BASE_LO_W >= BLK_W) begin : g_bad_blk
      $error("memwin_decode: block granularity settings inconsistent");
   end

   logic [ADDR_W-1:0] masked;
   logic [WID_W-1:0]  width;
   logic              in_io;
   logic              in_win;
   logic [LOC_W-1:0]  local_d;
   logic              bank_d;
   logic              strobe_d;
   logic              strobe_rise;

   memwin_addr_mask #(.ADDR_W(ADDR_W), .MIN_AW(MIN_AW)) u_mask (
      .addr_i  (bus_addr),
      .mode_i  (width_mode),
      .masked_o(masked),
      .width_o (width)
   );

   memwin_io_guard #(.ADDR_W(ADDR_W), .IO_LSB0(IO_LSB0)) u_io (
      .masked_i(masked),
      .width_i (width),
      .sel_i   (iopage_sel),
      .in_io_o (in_io)
   );

   memwin_range_cmp #(
      .BLK_W(BLK_W), .BASE_LO_W(BASE_LO_W), .SIZE_LO_W(SIZE_LO_W), .SIZE_HI_W(SIZE_HI_W)
   ) u_range (
      .blk_i    (masked[ADDR_W-1:BLK_LSB]),
      .base_lo_i(base_lo),
      .base_hi_i(base_hi),
      .size_lo_i(size_lo),
      .size_hi_i(size_hi),
      .in_win_o (in_win)
   );

   memwin_local_map #(.ADDR_W(ADDR_W), .SMALL_DEV_AW(SMALL_DEV_AW), .LOC_W(LOC_W)) u_map (
      .masked_i(masked),
      .large_i (dev_large),
      .local_o (local_d),
      .bank_o  (bank_d)
   );

   assign strobe_rise = addr_strobe & ~strobe_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_d <= 1'b0;
         hit_o    <= 1'b0;
         local_o  <= '0;
         bank_o   <= 1'b0;
      end else begin
         strobe_d <= addr_strobe;
         if (strobe_rise) begin
            hit_o   <= in_win & ~in_io;
            local_o <= local_d;
            bank_o  <= bank_d;
         end
      end
   end
endmodule

// File: rtl/memwin_decode_chk.sv
module memwin_decode_chk #(
   parameter int ADDR_W       = 22,
   parameter int SMALL_DEV_AW = 16,
   parameter int LOC_W        = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_strobe,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [2:0]        width_mode,
   input logic              dev_large,
   input logic              hit_o,
   input logic [LOC_W-1:0]  local_o,
   input logic              bank_o
);
   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (!hit_o && local_o == '0 && !bank_o));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(addr_strobe) |=> ($stable(hit_o) && $stable(local_o) && $stable(bank_o)));

   assert_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_strobe) |=> local_o[SMALL_DEV_AW-1:0] == $past(bus_addr[SMALL_DEV_AW:1]));

   assert_small_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(addr_strobe) && !dev_large) |=>
         (bank_o == $past(bus_addr[SMALL_DEV_AW+1]) && local_o[LOC_W-1:SMALL_DEV_AW] == '0));

   assert_io_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(addr_strobe) && width_mode >= 3'd4 && (&bus_addr[ADDR_W-1:11])) |=> !hit_o);
endmodule

bind memwin_decode memwin_decode_chk #(
   .ADDR_W(ADDR_W), .SMALL_DEV_AW(SMALL_DEV_AW), .LOC_W(LOC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_strobe(addr_strobe),
   .bus_addr   (bus_addr),
   .width_mode (width_mode),
   .dev_large  (dev_large),
   .hit_o      (hit_o),
   .local_o    (local_o),
   .bank_o     (bank_o)
);

// File: tb/memwin_decode_bench.sv
module memwin_decode_bench;
   localparam int VW = 44;
   localparam int NV = 24;
   // addr, base_lo, base_hi, size_lo, size_hi, width_mode, iopage_sel, dev_large, expected hit
   localparam logic [VW-1:0] VEC [NV] = '{
      {22'h000000, 5'd0,  4'd0,  4'd15, 2'd0, 3'd4, 2'd0, 1'b0, 1'b1},
      {22'h03FFFE, 5'd0,  4'd0,  4'd15, 2'd0, 3'd4, 2'd0, 1'b0, 1'b1},
      {22'h040000, 5'd0,  4'd0,  4'd15, 2'd0, 3'd4, 2'd0, 1'b0, 1'b0},
      {22'h005FFE, 5'd3,  4'd0,  4'd0,  2'd0, 3'd4, 2'd0, 1'b0, 1'b0},
      {22'h006000, 5'd3,  4'd0,  4'd0,  2'd0, 3'd4, 2'd0, 1'b1, 1'b1},
      {22'h009FFE, 5'd3,  4'd0,  4'd0,  2'd0, 3'd4, 2'd0, 1'b1, 1'b1},
      {22'h00A000, 5'd3,  4'd0,  4'd0,  2'd0, 3'd4, 2'd0, 1'b1, 1'b0},
      {22'h13FFFE, 5'd0,  4'd1,  4'd15, 2'd3, 3'd4, 2'd0, 1'b1, 1'b1},
      {22'h140000, 5'd0,  4'd1,  4'd15, 2'd3, 3'd4, 2'd0, 1'b1, 1'b0},
      {22'h3C1000, 5'd0,  4'd0,  4'd15, 2'd0, 3'd0, 2'd0, 1'b0, 1'b1},
      {22'h03F800, 5'd0,  4'd0,  4'd15, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0},
      {22'h03F7FE, 5'd0,  4'd0,  4'd15, 2'd0, 3'd0, 2'd0, 1'b0, 1'b1},
      {22'h03F7FE, 5'd0,  4'd0,  4'd15, 2'd0, 3'd0, 2'd1, 1'b0, 1'b0},
      {22'h0FDFFE, 5'd0,  4'd3,  4'd15, 2'd0, 3'd2, 2'd2, 1'b1, 1'b1},
      {22'h0FE000, 5'd0,  4'd3,  4'd15, 2'd0, 3'd2, 2'd2, 1'b1, 1'b0},
      {22'h3FF7FE, 5'd31, 4'd15, 4'd0,  2'd0, 3'd7, 2'd0, 1'b1, 1'b1},
      {22'h3FF800, 5'd31, 4'd15, 4'd0,  2'd0, 3'd7, 2'd0, 1'b1, 1'b0},
      {22'h3FF7FE, 5'd31, 4'd15, 4'd0,  2'd0, 3'd1, 2'd0, 1'b1, 1'b0},
      {22'h020000, 5'd0,  4'd0,  4'd15, 2'd0, 3'd4, 2'd0, 1'b0, 1'b1},
      {22'h05FFFE, 5'd16, 4'd0,  4'd15, 2'd0, 3'd4, 2'd0, 1'b0, 1'b1},
      {22'h04FFFE, 5'd0,  4'd0,  4'd3,  2'd1, 3'd4, 2'd0, 1'b1, 1'b1},
      {22'h050000, 5'd0,  4'd0,  4'd3,  2'd1, 3'd4, 2'd0, 1'b1, 1'b0},
      {22'h3FE000, 5'd31, 4'd15, 4'd0,  2'd0, 3'd4, 2'd3, 1'b1, 1'b0},
      {22'h3FE000, 5'd31, 4'd15, 4'd0,  2'd0, 3'd4, 2'd1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_strobe = 1'b0;
   logic [21:0] bus_addr = '0;
   logic [4:0]  base_lo = '0;
   logic [3:0]  base_hi = '0;
   logic [3:0]  size_lo = '0;
   logic [1:0]  size_hi = '0;
   logic [2:0]  width_mode = 3'd4;
   logic [1:0]  iopage_sel = '0;
   logic        dev_large = 1'b0;
   logic        hit_o;
   logic [17:0] local_o;
   logic        bank_o;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   memwin_decode u_memwin_decode (
      .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .bus_addr(bus_addr),
      .base_lo(base_lo), .base_hi(base_hi), .size_lo(size_lo), .size_hi(size_hi),
      .width_mode(width_mode), .iopage_sel(iopage_sel), .dev_large(dev_large),
      .hit_o(hit_o), .local_o(local_o), .bank_o(bank_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [21:0] mask_addr(input logic [21:0] a, input logic [2:0] wm);
      int w = 18 + ((wm > 3'd4) ? 4 : int'(wm));
      return a & 22'((64'd1 << w) - 1);
   endfunction

   task automatic apply(input logic [VW-1:0] v);
      @(negedge clk);
      bus_addr   = v[43:22];
      base_lo    = v[21:17];
      base_hi    = v[16:13];
      size_lo    = v[12:9];
      size_hi    = v[8:7];
      width_mode = v[6:4];
      iopage_sel = v[3:2];
      dev_large  = v[1];
      addr_strobe = 1'b1;
      @(negedge clk);
      addr_strobe = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [21:0] m;
      logic [17:0] held_loc;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset hit", 32'(hit_o), 32'd0);
      check("R8 reset local", 32'(local_o), 32'd0);
      check("R8 reset bank", 32'(bank_o), 32'd0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R6 R9 table walk
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         m = mask_addr(VEC[i][43:22], VEC[i][6:4]);
         check($sformatf("R1/R6 vec %0d hit", i), 32'(hit_o), 32'(VEC[i][0]));
         if (VEC[i][1]) begin
            check($sformatf("R3 R4 vec %0d local", i), 32'(local_o), 32'(m[18:1]));
            check($sformatf("R4 vec %0d bank", i), 32'(bank_o), 32'(m[19]));
         end else begin
            check($sformatf("R3 R4 vec %0d local", i), 32'(local_o), 32'({2'b00, m[16:1]}));
            check($sformatf("R4 vec %0d bank", i), 32'(bank_o), 32'(m[17]));
         end
      end

      // R7: address change with strobe low has no effect
      apply(VEC[0]);
      held_loc = local_o;
      bus_addr = 22'h040000;
      repeat (2) @(negedge clk);
      check("R7 strobe low hit held", 32'(hit_o), 32'd1);
      check("R7 strobe low local held", 32'(local_o), 32'(held_loc));

      // R7: strobe held high, second address ignored
      @(negedge clk);
      bus_addr = 22'h000100;
      addr_strobe = 1'b1;
      @(negedge clk);
      check("R7 first sample local", 32'(local_o), 32'h80);
      bus_addr = 22'h040000;
      repeat (3) @(negedge clk);
      check("R7 strobe high hit held", 32'(hit_o), 32'd1);
      check("R7 strobe high local held", 32'(local_o), 32'h80);
      addr_strobe = 1'b0;

      // R8: reset during operation clears outputs
      apply(VEC[18]);
      check("R4 bank before reset", 32'(bank_o), 32'd1);
      #3 rst_n = 1'b0;
      #2;
      check("R8 mid reset hit", 32'(hit_o), 32'd0);
      check("R8 mid reset bank", 32'(bank_o), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule